// File: doc/BRIEF.md
# Scaled Accumulator Datapath

This block is the arithmetic core around a 32-bit accumulator. A 16-bit data word enters through a scaling shifter. The shifter moves it left by 0 to 16 places and widens it to 32 bits. The shift count comes either from an immediate field or from a small shift-count register inside the block. Depending on a sign mode input, the word is first sign-extended or zero-extended.

An operation code then does one of the following: loads the scaled value, the external product or the buffer into the accumulator, or combines it with the accumulator by add, subtract or a bitwise logic operation. Other codes shift the accumulator right, copy it into a 32-bit buffer register, or run a signed min/max compare between accumulator and buffer.

Every cycle the block also presents the accumulator as two registered 16-bit store words, each shifted left by 0 to 7 places. This store path never alters the accumulator.

Top module: `acc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, buffer, carry, shift-count register and both store words become zero.
- R2: The scaled value is the extended input word shifted left by the count, with zeros filling the vacated low bits; an immediate count above 16 acts as 16.
- R3: When `cnt_from_reg` is 1, the count is the 4-bit shift-count register, which `cnt_wr` loads from `cnt_din[3:0]` at the clock edge; otherwise the count is `cnt_imm`.
- R4: With `sxm` = 1 the input word is sign-extended to 32 bits before shifting; with `sxm` = 0 it is zero-extended.
- R5: The operand select `opnd_sel` picks 0 = scaled value, 1 = `prod`, 2 = buffer, 3 = scaled value.
- R6: Operation codes 1 load, 2 add, 3 subtract, 4 AND, 5 OR and 6 XOR write the result into the accumulator at the next edge. Add sets carry to the carry-out of the unsigned 32-bit sum. Subtract sets carry to 1 when no borrow occurs (accumulator >= operand, unsigned). Logic operations and load leave carry unchanged.
- R7: One cycle after a clock edge, `st_hi` holds bits 31..16 of the accumulator shifted left by `st_shift` (0 to 7). The lost upper bits are discarded and the low half's top bits fill its bottom. The accumulator is unchanged by this.
- R8: One cycle after a clock edge, `st_lo` holds the low accumulator half shifted left by `st_shift`, with zeros filling its low bits.
- R9: Code 8 shifts the accumulator right by `rsh_m1`+1 places (1 to 16). The shift is arithmetic when `sxm` = 1 and logical when `sxm` = 0.
- R10: Code 9 (minimum) and code 10 (maximum) compare accumulator and buffer as signed values. If the accumulator is strictly less (code 9) or strictly greater (code 10), it is copied into the buffer and carry becomes 1. Otherwise the buffer is copied into the accumulator and carry becomes 0.
- R11: Code 7 copies the accumulator into the buffer. Code 0 and codes 11 to 15 leave accumulator, buffer and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| din | input | 16 | Data word to the scaling shifter |
| cnt_imm | input | 5 | Immediate shift count |
| cnt_from_reg | input | 1 | Take shift count from the count register |
| cnt_wr | input | 1 | Load the count register |
| cnt_din | input | 16 | Count register write data (low 4 bits used) |
| sxm | input | 1 | Sign mode for input extension and right shift |
| prod | input | 32 | Product operand |
| opnd_sel | input | 2 | Second operand select |
| rsh_m1 | input | 4 | Right shift amount minus one |
| st_shift | input | 3 | Store path left shift |
| acc_q | output | 32 | Accumulator |
| accb_q | output | 32 | Accumulator buffer |
| carry_q | output | 1 | Carry flag |
| st_hi | output | 16 | Shifted high store word |
| st_lo | output | 16 | Shifted low store word |

## Verification
The embedded properties assume that every input is a known value on each active edge and that `rst` is held for at least one edge before operation begins. They also assume that the control fields stay in their declared ranges. The stimulus meets these conditions because it changes inputs only on the falling edge and starts with a multi-cycle reset. It draws every field from its full legal range, including immediate counts above 16, unused operation codes and all store shifts. Directed cases cover equal operands in the compare, the count register path and sign-mode changes.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LOAD = 4'd1,
    OP_ADD  = 4'd2,
    OP_SUB  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_SAVE = 4'd7,
    OP_RSH  = 4'd8,
    OP_MIN  = 4'd9,
    OP_MAX  = 4'd10
  } acc_op_e;

  typedef enum logic [1:0] {
    SRC_SCALED  = 2'd0,
    SRC_PROD    = 2'd1,
    SRC_BUF     = 2'd2,
    SRC_SCALED2 = 2'd3
  } acc_src_e;
endpackage

// File: rtl/acc_scaler.sv
module acc_scaler #(
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int CW = 5,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] cnt_imm,
  input  logic          use_reg,
  input  logic [RW-1:0] reg_cnt,
  input  logic          sxm,
  output logic [AW-1:0] scaled
);
  localparam int MAXSH = DW;
  localparam logic [CW-1:0] MAXC = CW'(MAXSH);

  logic [CW-1:0] cnt;
  logic [AW-1:0] ext;

  always_comb begin
    if (use_reg) cnt = CW'(reg_cnt);
    else if (cnt_imm > MAXC) cnt = MAXC;
    else cnt = cnt_imm;
  end

  always_comb begin
    if (sxm) ext = {{(AW-DW){din[DW-1]}}, din};
    else     ext = {{(AW-DW){1'b0}}, din};
  end

  assign scaled = ext << cnt;

  // R2: vacated low bits are zero
  assert_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (scaled & ((AW'(1) << cnt) - AW'(1))) == '0);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int AW = 32,
  parameter int RSW = 4
) (
  input  logic [3:0]     op,
  input  logic [AW-1:0]  acc,
  input  logic [AW-1:0]  accb,
  input  logic           carry,
  input  logic [AW-1:0]  opnd,
  input  logic           sxm,
  input  logic [RSW-1:0] rsh_m1,
  output logic [AW-1:0]  acc_n,
  output logic [AW-1:0]  accb_n,
  output logic           carry_n
);
  logic [AW:0]   sum;
  logic [AW:0]   dif;
  logic [RSW:0]  rsh;
  logic          lt;
  logic          gt;
  acc_op_e       opc;

  assign opc = acc_op_e'(op);
  assign sum = {1'b0, acc} + {1'b0, opnd};
  assign dif = {1'b0, acc} - {1'b0, opnd};
  assign rsh = {1'b0, rsh_m1} + 1'b1;
  assign lt  = $signed(acc) < $signed(accb);
  assign gt  = $signed(acc) > $signed(accb);

  always_comb begin
    acc_n   = acc;
    accb_n  = accb;
    carry_n = carry;
    case (opc)
      OP_LOAD: acc_n = opnd;
      OP_ADD:  begin acc_n = sum[AW-1:0]; carry_n = sum[AW]; end
      OP_SUB:  begin acc_n = dif[AW-1:0]; carry_n = ~dif[AW]; end
      OP_AND:  acc_n = acc & opnd;
      OP_OR:   acc_n = acc | opnd;
      OP_XOR:  acc_n = acc ^ opnd;
      OP_SAVE: accb_n = acc;
      OP_RSH:  begin
        if (sxm) acc_n = AW'($signed(acc) >>> rsh);
        else     acc_n = acc >> rsh;
      end
      OP_MIN:  begin
        if (lt) begin accb_n = acc; carry_n = 1'b1; end
        else    begin acc_n = accb; carry_n = 1'b0; end
      end
      OP_MAX:  begin
        if (gt) begin accb_n = acc; carry_n = 1'b1; end
        else    begin acc_n = accb; carry_n = 1'b0; end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_store.sv
module acc_store #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] acc,
  input  logic [SW-1:0] sh,
  output logic [AW/2-1:0] hi_q,
  output logic [AW/2-1:0] lo_q
);
  localparam int HW = AW / 2;

  logic [AW-1:0] full_sh;
  logic [HW-1:0] lo_sh;

  assign full_sh = acc << sh;
  assign lo_sh   = acc[HW-1:0] << sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= full_sh[AW-1:HW];
      lo_q <= lo_sh;
    end
  end

  // R7: unshifted store presents the high half as is
  assert_store_plain_R7: assert property (@(posedge clk) disable iff (rst)
    (sh == '0) |=> (hi_q == $past(acc[AW-1:HW])));
  // R8: any nonzero shift leaves bit 0 of the low word clear
  assert_store_lo_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (sh != '0) |=> !lo_q[0]);
endmodule

// File: rtl/acc_unit.sv
module acc_unit
  import acc_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 32,
  parameter int CW  = 5,
  parameter int RW  = 4,
  parameter int SW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] cnt_imm,
  input  logic          cnt_from_reg,
  input  logic          cnt_wr,
  input  logic [DW-1:0] cnt_din,
  input  logic          sxm,
  input  logic [AW-1:0] prod,
  input  logic [1:0]    opnd_sel,
  input  logic [RW-1:0] rsh_m1,
  input  logic [SW-1:0] st_shift,
  output logic [AW-1:0] acc_q,
  output logic [AW-1:0] accb_q,
  output logic          carry_q,
  output logic [AW/2-1:0] st_hi,
  output logic [AW/2-1:0] st_lo
);
  logic [RW-1:0] cnt_reg;
  logic [AW-1:0] scaled;
  logic [AW-1:0] opnd;
  logic [AW-1:0] acc_n;
  logic [AW-1:0] accb_n;
  logic          carry_n;

  acc_scaler #(.DW(DW), .AW(AW), .CW(CW), .RW(RW)) u_scaler (
    .clk(clk), .rst(rst), .din(din), .cnt_imm(cnt_imm),
    .use_reg(cnt_from_reg), .reg_cnt(cnt_reg), .sxm(sxm), .scaled(scaled)
  );

  always_comb begin
    case (acc_src_e'(opnd_sel))
      SRC_PROD: opnd = prod;
      SRC_BUF:  opnd = accb_q;
      default:  opnd = scaled;
    endcase
  end

  acc_alu #(.AW(AW), .RSW(RW)) u_alu (
    .op(op), .acc(acc_q), .accb(accb_q), .carry(carry_q), .opnd(opnd),
    .sxm(sxm), .rsh_m1(rsh_m1), .acc_n(acc_n), .accb_n(accb_n),
    .carry_n(carry_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      accb_q  <= '0;
      carry_q <= 1'b0;
      cnt_reg <= '0;
    end else begin
      acc_q   <= acc_n;
      accb_q  <= accb_n;
      carry_q <= carry_n;
      if (cnt_wr) cnt_reg <= cnt_din[RW-1:0];
    end
  end

  acc_store #(.AW(AW), .SW(SW)) u_store (
    .clk(clk), .rst(rst), .acc(acc_q), .sh(st_shift),
    .hi_q(st_hi), .lo_q(st_lo)
  );

  // R10: after a minimum compare both registers agree
  assert_min_agree_R10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MIN) |=> (acc_q == accb_q));
  // R10: strict signed win on maximum sets carry
  assert_max_carry_R10: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_MAX) && ($signed(acc_q) > $signed(accb_q))) |=> carry_q);
  // R9: logical right shift clears the top bit
  assert_lsr_top_R9: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_RSH) && !sxm) |=> !acc_q[AW-1]);
  // R11: idle code keeps the buffer
  assert_nop_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NOP) |=> $stable(accb_q));
endmodule

// File: tb/acc_unit_bench.sv
module acc_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = '0;
  logic [15:0] din = '0;
  logic [4:0]  cnt_imm = '0;
  logic        cnt_from_reg = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_din = '0;
  logic        sxm = 1'b0;
  logic [31:0] prod = '0;
  logic [1:0]  opnd_sel = '0;
  logic [3:0]  rsh_m1 = '0;
  logic [2:0]  st_shift = '0;
  logic [31:0] acc_q, accb_q;
  logic        carry_q;
  logic [15:0] st_hi, st_lo;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [31:0] m_acc = '0, m_accb = '0;
  logic        m_c = 1'b0;
  logic [3:0]  m_cnt = '0;
  logic [15:0] m_hi = '0, m_lo = '0;

  always #5 clk = ~clk;

  acc_unit u_acc_unit (
    .clk(clk), .rst(rst), .op(op), .din(din), .cnt_imm(cnt_imm),
    .cnt_from_reg(cnt_from_reg), .cnt_wr(cnt_wr), .cnt_din(cnt_din),
    .sxm(sxm), .prod(prod), .opnd_sel(opnd_sel), .rsh_m1(rsh_m1),
    .st_shift(st_shift), .acc_q(acc_q), .accb_q(accb_q), .carry_q(carry_q),
    .st_hi(st_hi), .st_lo(st_lo)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic string tag_of(input logic [3:0] o, input logic [1:0] s);
    case (o)
      4'd1:    return (s == 2'd0 || s == 2'd3) ? "R2/R4 load" : "R5 load";
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6: return "R6";
      4'd7:    return "R11 save";
      4'd8:    return "R9";
      4'd9, 4'd10: return "R10";
      default: return "R11 hold";
    endcase
  endfunction

  task automatic check32(input string t, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, a, e);
    end
  endtask

  // one operation: drive at negedge, model edge, compare at next negedge
  task automatic step(input logic [3:0] o, input logic [15:0] d, input logic [4:0] ci,
                      input logic fr, input logic wr, input logic [15:0] cd,
                      input logic sx, input logic [31:0] p, input logic [1:0] sel,
                      input logic [3:0] rs, input logic [2:0] ss);
    logic [31:0] ext, sc, opn, na, nb;
    logic [32:0] w;
    logic nc;
    int cnt, r;
    op = o; din = d; cnt_imm = ci; cnt_from_reg = fr; cnt_wr = wr; cnt_din = cd;
    sxm = sx; prod = p; opnd_sel = sel; rsh_m1 = rs; st_shift = ss;
    cnt = fr ? int'(m_cnt) : ((int'(ci) > 16) ? 16 : int'(ci));
    ext = sx ? {{16{d[15]}}, d} : {16'h0, d};
    sc = ext << cnt;
    opn = (sel == 2'd1) ? p : (sel == 2'd2) ? m_accb : sc;
    na = m_acc; nb = m_accb; nc = m_c; r = int'(rs) + 1;
    case (o)
      4'd1: na = opn;
      4'd2: begin w = {1'b0, m_acc} + {1'b0, opn}; na = w[31:0]; nc = w[32]; end
      4'd3: begin na = m_acc - opn; nc = (m_acc >= opn); end
      4'd4: na = m_acc & opn;
      4'd5: na = m_acc | opn;
      4'd6: na = m_acc ^ opn;
      4'd7: nb = m_acc;
      4'd8: na = sx ? 32'($signed(m_acc) >>> r) : (m_acc >> r);
      4'd9: if ($signed(m_acc) < $signed(m_accb)) begin nb = m_acc; nc = 1; end
            else begin na = m_accb; nc = 0; end
      4'd10: if ($signed(m_acc) > $signed(m_accb)) begin nb = m_acc; nc = 1; end
             else begin na = m_accb; nc = 0; end
      default: ;
    endcase
    m_hi = 16'((m_acc * (32'd1 << ss)) >> 16);
    m_lo = 16'(m_acc[15:0] * (16'd1 << ss));
    if (wr) m_cnt = cd[3:0];
    m_acc = na; m_accb = nb; m_c = nc;
    @(posedge clk);
    @(negedge clk);
    check32({tag_of(o, sel), " acc"}, acc_q, m_acc);
    check32({tag_of(o, sel), " buffer"}, accb_q, m_accb);
    check32({tag_of(o, sel), " carry"}, {31'h0, carry_q}, {31'h0, m_c});
    check32("R7 store high", {16'h0, st_hi}, {16'h0, m_hi});
    check32("R8 store low", {16'h0, st_lo}, {16'h0, m_lo});
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check32("R1 reset acc", acc_q, 32'h0);
    check32("R1 reset buffer", accb_q, 32'h0);
    check32("R1 reset carry", {31'h0, carry_q}, 32'h0);
    check32("R1 reset store", {st_hi, st_lo}, 32'h0);
    rst = 1'b0;
    // R2 R4: sign-extended load, shift 4
    step(4'd1, 16'h8001, 5'd4, 0, 0, 0, 1, 0, 2'd0, 0, 3'd0);
    check32("R4 sign load", acc_q, 32'hFFF8_0010);
    // R2: zero extend, count clamps to 16
    step(4'd1, 16'h8001, 5'd20, 0, 0, 0, 0, 0, 2'd0, 0, 3'd7);
    check32("R2 clamp", acc_q, 32'h8001_0000);
    // R3: count register loaded with 9, then used
    step(4'd0, 16'h0, 5'd0, 0, 1, 16'hFFF9, 0, 0, 2'd0, 0, 3'd3);
    step(4'd1, 16'h0003, 5'd0, 1, 0, 0, 0, 0, 2'd3, 0, 3'd1);
    check32("R3 count register", acc_q, 32'h0000_0600);
    step(4'd7, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 3'd0);
    // R5: product operand add with carry out
    step(4'd1, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 2'd1, 0, 3'd0);
    step(4'd2, 0, 0, 0, 0, 0, 0, 32'h0000_0002, 2'd1, 0, 3'd5);
    check32("R6 add carry", {31'h0, carry_q}, 32'h1);
    step(4'd3, 0, 0, 0, 0, 0, 0, 0, 2'd2, 0, 3'd2);
    // R9: arithmetic and logical right shifts
    step(4'd1, 0, 0, 0, 0, 0, 0, 32'h8000_0000, 2'd1, 0, 3'd0);
    step(4'd8, 0, 0, 0, 0, 0, 1, 0, 2'd0, 4'd15, 3'd0);
    check32("R9 arithmetic 16", acc_q, 32'hFFFF_8000);
    step(4'd8, 0, 0, 0, 0, 0, 0, 0, 2'd0, 4'd0, 3'd4);
    check32("R9 logical 1", acc_q, 32'h7FFF_C000);
    // R10: equal operands on max, then min
    step(4'd7, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 3'd0);
    step(4'd10, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 3'd0);
    check32("R10 equal max carry", {31'h0, carry_q}, 32'h0);
    step(4'd1, 0, 0, 0, 0, 0, 0, 32'hF000_0000, 2'd1, 0, 3'd0);
    step(4'd9, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 3'd6);
    check32("R10 min chose acc", accb_q, 32'hF000_0000);
    // R11: unused codes hold
    step(4'd13, 16'hFFFF, 5'd3, 0, 0, 0, 1, 32'h1234, 2'd1, 0, 3'd7);
    for (int i = 0; i < 4000; i++) begin
      step(4'($urandom % 16), 16'($urandom), 5'($urandom), 1'($urandom),
           (($urandom % 8) == 0), 16'($urandom), 1'($urandom), $urandom,
           2'($urandom), 4'($urandom), 3'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule